// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a down-counting interval timer that raises a periodic interrupt. An 8-bit scale value sets a prescaler. The prescaler divides the processor clock so that the 16-bit count steps down once every scale+1 cycles. A tick that arrives while the count is zero does three things: it reloads the count from a 16-bit period register, it raises the interrupt, and the cycle starts again. Interrupts are therefore spaced (period+1)·(scale+1) cycles apart.

Software reaches the three registers through a simple write port and a combinational read port, each with a 2-bit select. Select 0 is the count, 1 is the period, 2 is the scale (write data bits 7:0, read back zero-extended), and 3 is unused. An enable input freezes or releases the timer.

The count logic chooses one action in each cycle, in priority order:
- `ACT_LOAD`: software writes the count.
- `ACT_HOLD`: the timer is disabled.
- `ACT_WAIT`: the prescaler is still running down.
- `ACT_WRAP`: a tick arrives with the count at zero.
- `ACT_STEP`: a tick arrives with a non-zero count.

The transitions are set by the write strobe, the enable, the prescaler tick and the zero test on the count. The registered interrupt output follows the choice of `ACT_WRAP`.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count, period, scale and prescaler all read zero and `irq` is low.
- R2: Writes with `wr_sel` 0, 1 or 2 load the count, the period or the scale (bits 7:0) at the next clock edge. `rd_data` shows the register picked by `rd_sel` in the same cycle, with the scale zero-extended. Select 3 reads zero, and a write with select 3 changes nothing.
- R3: While enabled, the prescaler counts down from the scale value. It gives one tick in each scale+1 cycles, and it reloads from the scale register when it gives a tick. A scale of 0 gives a tick on every cycle.
- R4: A tick with a non-zero count lowers the count by exactly one. Cycles without a tick leave the count unchanged.
- R5: A tick while the count is zero loads the count from the period register. `irq` is high for exactly the cycle in which the reloaded value is visible.
- R6: With period 0 every tick raises `irq`. With scale 0 as well, `irq` stays high on every cycle.
- R7: In steady running, consecutive `irq` pulses are (period+1)·(scale+1) cycles apart.
- R8: While `tmr_en` is low, the count and the prescaler hold and `irq` stays low. Enabling resumes from the held values.
- R9: A count write takes priority over that cycle's step or reload, and that cycle raises no `irq`. The prescaler keeps running.
- R10: Writing the period or the scale does not disturb a count or prescale already in progress. A new scale takes effect at the next prescaler reload, and a new period at the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer run enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 period, 2 scale, 3 none |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target, same encoding |
| rd_data | output | 16 | Read data for `rd_sel` |
| irq | output | 1 | Interrupt pulse, high in the cycle the count reloads |

## Verification
The properties assume that the select inputs and the enable are at defined values on every edge after reset, and that a write strobe comes with a valid select and data in the same cycle. The bench changes all inputs only on the falling edge, so each edge sees one settled set of values. Random stimulus keeps the scale to 0–3 and the period to 0–5, so that many wraps, period-0 runs and write-versus-tick collisions happen within the run. Directed phases cover halting, writes to the unused select, and exact spacing of the interrupts.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_WAIT,
        ACT_STEP,
        ACT_WRAP,
        ACT_LOAD
    } act_e;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] pre,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    assign tick = run && (pre_q == '0);
    assign pre  = pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run) begin
            if (pre_q == '0) pre_q <= div;
            else             pre_q <= pre_q - 1'b1;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    act_e             act;

    // per-cycle action, priority: write, halt, prescale, wrap, step
    always_comb begin
        if (load)               act = ACT_LOAD;
        else if (!run)          act = ACT_HOLD;
        else if (!tick)         act = ACT_WAIT;
        else if (cnt_q == '0)   act = ACT_WRAP;
        else                    act = ACT_STEP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: cnt_q <= load_val;
                ACT_WRAP: cnt_q <= period;
                ACT_STEP: cnt_q <= cnt_q - 1'b1;
                ACT_HOLD,
                ACT_WAIT: cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (act == ACT_WRAP);
    end

    assign cnt = cnt_q;
    assign irq = irq_q;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] rd_data
);
    localparam int PAD_W = CNT_W - DIV_W;

    logic [CNT_W-1:0] period_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            div_q    <= '0;
        end else if (wr_en) begin
            unique case (sel_e'(wr_sel))
                SEL_PERIOD: period_q <= wr_data;
                SEL_SCALE:  div_q    <= wr_data[DIV_W-1:0];
                SEL_COUNT,
                SEL_NONE:   ;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel_e'(rd_sel))
            SEL_COUNT:  rd_data = cnt;
            SEL_PERIOD: rd_data = period_q;
            SEL_SCALE:  rd_data = {{PAD_W{1'b0}}, div_q};
            SEL_NONE:   rd_data = '0;
            default:    rd_data = '0;
        endcase
    end

    assign period = period_q;
    assign div    = div_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] pre_q;
    logic             tick;
    logic             cnt_wr;

    assign cnt_wr = wr_en && (sel_e'(wr_sel) == SEL_COUNT);

    ivt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .cnt     (cnt_q),
        .period  (period_q),
        .div     (div_q),
        .rd_data (rd_data)
    );

    ivt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_en),
        .div  (div_q),
        .pre  (pre_q),
        .tick (tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_en),
        .tick    (tick),
        .load    (cnt_wr),
        .load_val(wr_data),
        .period  (period_q),
        .cnt     (cnt_q),
        .irq     (irq)
    );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic [DIV_W-1:0] pre,
    input logic [CNT_W-1:0] period,
    input logic             irq
);
    logic wr_cnt;
    assign wr_cnt = wr_en && (wr_sel == 2'd0);

    a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == $past(period)));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_data) && !irq));

    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt) |=> ($stable(cnt) && $stable(pre) && !irq));

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_cnt && pre == '0 && cnt != '0) |=> (cnt == $past(cnt) - 1'b1 && !irq));

    a_r3_prescale_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_cnt && pre != '0) |=> ($stable(cnt) && !irq && pre == $past(pre) - 1'b1));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tmr_en),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .cnt    (cnt_q),
    .pre    (pre_q),
    .period (period_q),
    .irq    (irq)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state computed from the requirements
    logic [15:0] m_cnt = 16'd0, m_per = 16'd0;
    logic [7:0]  m_div = 8'd0, m_pre = 8'd0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    ivt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [15:0] m_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_cnt;
            2'd1:    return m_per;
            2'd2:    return {8'd0, m_div};
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_step();
        logic tick;
        logic wc;
        tick = tmr_en && (m_pre == 8'd0);
        wc   = wr_en && (wr_sel == 2'd0);
        m_irq = 1'b0;
        if (wc)             m_cnt = wr_data;
        else if (tick) begin
            if (m_cnt == 16'd0) begin m_cnt = m_per; m_irq = 1'b1; end
            else                m_cnt = m_cnt - 16'd1;
        end
        if (tmr_en) m_pre = (m_pre == 8'd0) ? m_div : m_pre - 8'd1;
        if (wr_en && wr_sel == 2'd1) m_per = wr_data;
        if (wr_en && wr_sel == 2'd2) m_div = wr_data[7:0];
    endtask

    task automatic check(input string req);
        logic [15:0] e;
        e = m_read(rd_sel);
        n_chk++;
        if (irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq, m_irq);
        end
        n_chk++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s rd_data sel %0d: actual %0h expected %0h", req, rd_sel, rd_data, e);
        end
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d, input string req);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc(req);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int last_irq;
        int gap;
        int cyc_no;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on all registers
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 check("R1 reset");
        end

        // R2: register access and unused select ignored
        wr(2'd1, 16'h1234, "R2 period write");
        wr(2'd2, 16'hABCD, "R2 scale write");
        wr(2'd0, 16'h0077, "R2 count write");
        wr(2'd3, 16'hFFFF, "R2 unused select write");
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 check("R2 readback");
        end

        // R8: halted timer holds
        wr(2'd2, 16'd2, "R8 setup");
        repeat (6) cyc("R8 halted");
        rd_sel = 2'd0;
        tmr_en = 1'b1;
        repeat (7) cyc("R3 R4 resumed");
        tmr_en = 1'b0;
        repeat (4) cyc("R8 halt mid prescale");
        tmr_en = 1'b1;
        repeat (4) cyc("R8 resume");

        // R6: period 0, scale 0 -> irq every cycle
        tmr_en = 1'b0;
        wr(2'd2, 16'd0, "R6 setup");
        wr(2'd1, 16'd0, "R6 setup");
        wr(2'd0, 16'd0, "R6 setup");
        tmr_en = 1'b1;
        repeat (2) cyc("R6 first tick");
        repeat (5) begin
            cyc("R6 every cycle");
            n_chk++;
            if (irq !== 1'b1) begin
                n_fail++;
                $display("FAIL R6 continuous irq: actual %0b expected 1", irq);
            end
        end

        // R7 / R5: spacing scale 3 period 2 -> 12 cycles
        tmr_en = 1'b0;
        wr(2'd2, 16'd3, "R7 setup");
        wr(2'd1, 16'd2, "R7 setup");
        tmr_en = 1'b1;
        last_irq = -1; gap = 0; cyc_no = 0;
        repeat (60) begin
            cyc("R5 R7 run");
            cyc_no++;
            if (irq) begin
                if (last_irq >= 0) gap = cyc_no - last_irq;
                last_irq = cyc_no;
            end
        end
        n_chk++;
        if (gap != 12) begin
            n_fail++;
            $display("FAIL R7 irq spacing: actual %0d expected 12", gap);
        end

        // R9: count write collides with wrap
        wr(2'd2, 16'd0, "R9 setup");
        wr(2'd0, 16'd0, "R9 setup");
        wr(2'd0, 16'd5, "R9 write over wrap");
        repeat (3) cyc("R9 after write");

        // R10: scale change mid prescale
        wr(2'd2, 16'd6, "R10 setup");
        repeat (3) cyc("R10 running");
        wr(2'd2, 16'd1, "R10 scale change");
        wr(2'd1, 16'd9, "R10 period change");
        repeat (20) cyc("R10 after change");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            tmr_en = ($urandom_range(0, 9) != 0);
            rd_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1'b1;
                wr_sel = 2'($urandom_range(0, 3));
                case (wr_sel)
                    2'd2:    wr_data = 16'($urandom_range(0, 3));
                    2'd1:    wr_data = 16'($urandom_range(0, 5));
                    default: wr_data = 16'($urandom_range(0, 8));
                endcase
            end else begin
                wr_en = 1'b0;
            end
            cyc("R3 R4 R5 R9 R10 random");
        end
        wr_en = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule